// File: doc/BRIEF.md
# Latched Interrupt Status Register

This block gathers a set of interrupt causes into one 8-bit read-only status word and raises a single interrupt line while any bit of that word is set. Four channel bits, a host time-out bit, a PCM test-data bit and a clock-failure bit are kept in separate latches. Each kind of bit has its own clear source. A channel bit clears when the related I/O register is read, or when its mask is raised. The PCM bit clears when its test data register is accessed. The time-out and clock-failure bits clear only on a status read, and only once their cause has gone low.

A mode pin picks how the channel bits map to their sources. In dynamic mode each channel bit follows its own channel request and mask. In static mode bit 0 gathers requests from the general I/O lines and bit 2 gathers requests from the chip-select lines used as I/O. Bits 1 and 3 are then held at zero. Every pin is a plain level or a one-cycle strobe. There is no data stream at the edge of the block, so it has no valid/ready handshake. All status bits are registered, and a cause seen at one clock edge is visible on `stat` just after that edge.

Top module: `irq_status_reg`

## Requirements
- R1: After reset, `stat` is 8'h00 and `irq` is low.
- R2: In dynamic mode (`mode_static`=0), `ch_req[n]` high with `mask[n]` low sets `stat[n]` (n=0..3) at the next edge. The bit then holds until a clear source acts on it.
- R3: In dynamic mode, `io_rd[n]` high or `mask[n]` high clears `stat[n]` at the next edge. While `mask[n]` is high, `ch_req[n]` cannot set the bit.
- R4: In static mode (`mode_static`=1), any bit of `gio_req` sets `stat[0]` and any bit of `cs_req` sets `stat[2]`. `io_rd[0]` clears `stat[0]` and `io_rd[2]` clears `stat[2]`. `ch_req` and `mask` have no effect in this mode.
- R5: In static mode, `stat[1]` and `stat[3]` read as 0 from the edge after the mode is seen.
- R6: `stat[6]` (host time-out) sets at each edge where `tmo_cause` is high. A `stat_rd` clears it only in a cycle where `tmo_cause` is low.
- R7: `stat[4]` (clock failure) sets at each edge where `ckf_cause` is high. A `stat_rd` clears it only in a cycle where `ckf_cause` is low.
- R8: `stat[5]` (PCM test) sets when `pcm_rx_rdy` or `pcm_tx_req` is high. It clears when `pcm_acc` is high.
- R9: If a set and a clear reach the same bit in the same cycle, the bit ends up set.
- R10: `stat[7]` is always 0, and `irq` is high exactly when some bit of `stat` is 1.
- R11: `stat_rd` has no effect on `stat[3:0]` or `stat[5]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_static | input | 1 | 1 selects static channel mapping, 0 selects dynamic |
| ch_req | input | 4 | Per-channel interrupt requests (dynamic mode) |
| gio_req | input | GIO_W | Requests from the general I/O lines (static mode) |
| cs_req | input | CS_W | Requests from chip-select lines used as I/O (static mode) |
| io_rd | input | 4 | Strobes marking reads of the related I/O registers |
| mask | input | 4 | Per-channel mask bits (dynamic mode) |
| tmo_cause | input | 1 | Host serial interface time-out cause level |
| ckf_cause | input | 1 | PCM master clock failure cause level |
| pcm_rx_rdy | input | 1 | PCM test receive data ready |
| pcm_tx_req | input | 1 | PCM test transmit data needed |
| pcm_acc | input | 1 | Strobe marking a read or write of the PCM test data register |
| stat_rd | input | 1 | Strobe marking a read of the status register |
| stat | output | 8 | Status word: bit 6 time-out, 5 PCM test, 4 clock failure, 3..0 channels, 7 zero |
| irq | output | 1 | Interrupt request, OR of all status bits |

## Verification
The assertions check the local rules on every cycle. Each latch obeys set-wins, clear and hold. A masked dynamic channel never shows set. Bits 1 and 3 stay low in static mode. An active time-out or clock-failure cause always leaves its bit set. Only the bench scenarios show the rules that depend on a sequence of events. These are a status read that is ignored while a cause is still high and then takes effect once the cause drops, the change of channel sources across a mode switch, and the way independent clear strobes interleave. The bench covers them with directed sequences and with a long random sweep against a per-bit model.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int STAT_W  = 8;
  localparam int N_CH    = 4;
  localparam int BIT_CKF = 4;
  localparam int BIT_PCM = 5;
  localparam int BIT_TMO = 6;
  localparam int BIT_RSV = 7;
  localparam int ST_BIT_GIO = 0;
  localparam int ST_BIT_CS  = 2;
endpackage

// File: rtl/irq_latch_bit.sv
module irq_latch_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  // R3
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/irq_chan_map.sv
module irq_chan_map #(
  parameter int GIO_W = 12,
  parameter int CS_W  = 4
) (
  input  logic                                 mode_static,
  input  logic [irq_status_pkg::N_CH-1:0]      ch_req,
  input  logic [GIO_W-1:0]                     gio_req,
  input  logic [CS_W-1:0]                      cs_req,
  input  logic [irq_status_pkg::N_CH-1:0]      io_rd,
  input  logic [irq_status_pkg::N_CH-1:0]      mask,
  output logic [irq_status_pkg::N_CH-1:0]      set_o,
  output logic [irq_status_pkg::N_CH-1:0]      clr_o
);
  import irq_status_pkg::*;

  logic gio_any, cs_any;
  assign gio_any = |gio_req;
  assign cs_any  = |cs_req;

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    logic dyn_set, dyn_clr, st_set, st_clr;
    assign dyn_set = ch_req[n] & ~mask[n];
    assign dyn_clr = io_rd[n] | mask[n];
    if (n == ST_BIT_GIO) begin : g_gio
      assign st_set = gio_any;
      assign st_clr = io_rd[n];
    end else if (n == ST_BIT_CS) begin : g_cs
      assign st_set = cs_any;
      assign st_clr = io_rd[n];
    end else begin : g_unused
      assign st_set = 1'b0;
      assign st_clr = 1'b1;
    end
    assign set_o[n] = mode_static ? st_set : dyn_set;
    assign clr_o[n] = mode_static ? st_clr : dyn_clr;
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int GIO_W = 12,
  parameter int CS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_static,
  input  logic [3:0]       ch_req,
  input  logic [GIO_W-1:0] gio_req,
  input  logic [CS_W-1:0]  cs_req,
  input  logic [3:0]       io_rd,
  input  logic [3:0]       mask,
  input  logic             tmo_cause,
  input  logic             ckf_cause,
  input  logic             pcm_rx_rdy,
  input  logic             pcm_tx_req,
  input  logic             pcm_acc,
  input  logic             stat_rd,
  output logic [7:0]       stat,
  output logic             irq
);
  import irq_status_pkg::*;

  logic [N_CH-1:0] ch_set, ch_clr;
  logic [STAT_W-1:0] set_v, clr_v, q_v;

  irq_chan_map #(.GIO_W(GIO_W), .CS_W(CS_W)) u_map (
    .mode_static (mode_static),
    .ch_req      (ch_req),
    .gio_req     (gio_req),
    .cs_req      (cs_req),
    .io_rd       (io_rd),
    .mask        (mask),
    .set_o       (ch_set),
    .clr_o       (ch_clr)
  );

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[N_CH-1:0] = ch_set;
    clr_v[N_CH-1:0] = ch_clr;
    set_v[BIT_TMO]  = tmo_cause;
    clr_v[BIT_TMO]  = stat_rd & ~tmo_cause;
    set_v[BIT_CKF]  = ckf_cause;
    clr_v[BIT_CKF]  = stat_rd & ~ckf_cause;
    set_v[BIT_PCM]  = pcm_rx_rdy | pcm_tx_req;
    clr_v[BIT_PCM]  = pcm_acc;
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (b == BIT_RSV) begin : g_rsv
      assign q_v[b] = 1'b0;
    end else begin : g_lat
      irq_latch_bit u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v[b]),
        .clr_i (clr_v[b]),
        .q_o   (q_v[b])
      );
    end
  end

  assign stat = q_v;
  assign irq  = |q_v;

  // R5
  static_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_static |=> (!stat[1] && !stat[3]));
  // R6
  tmo_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_cause |=> stat[BIT_TMO]);
  // R7
  ckf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ckf_cause |=> stat[BIT_CKF]);

  for (genvar n = 0; n < N_CH; n++) begin : g_mchk
    // R3
    masked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_static && mask[n]) |=> !stat[n]);
  end
endmodule

// File: tb/sim_irq_status_reg.sv
module sim_irq_status_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic ms, tmo, ckf, prx, ptx, pacc, srd;
  logic [3:0] creq, iord, msk;
  logic [11:0] gio;
  logic [3:0] cs;
  logic [7:0] stat;
  logic irq;
  logic [7:0] exp_s;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  irq_status_reg u0 (
    .clk(clk), .rst_n(rst_n), .mode_static(ms), .ch_req(creq),
    .gio_req(gio), .cs_req(cs), .io_rd(iord), .mask(msk),
    .tmo_cause(tmo), .ckf_cause(ckf), .pcm_rx_rdy(prx),
    .pcm_tx_req(ptx), .pcm_acc(pacc), .stat_rd(srd),
    .stat(stat), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_pulses();
    creq = '0; gio = '0; cs = '0; iord = '0; prx = 0; ptx = 0; pacc = 0; srd = 0;
  endtask

  task automatic model();
    logic [7:0] e;
    e = exp_s;
    for (int n = 0; n < 4; n++) begin
      logic s, c;
      if (!ms) begin
        s = creq[n] & ~msk[n];
        c = iord[n] | msk[n];
      end else if (n == 0) begin
        s = |gio; c = iord[0];
      end else if (n == 2) begin
        s = |cs; c = iord[2];
      end else begin
        s = 0; c = 1;
      end
      e[n] = s ? 1'b1 : (c ? 1'b0 : e[n]);
    end
    e[6] = tmo ? 1'b1 : (srd ? 1'b0 : e[6]);
    e[4] = ckf ? 1'b1 : (srd ? 1'b0 : e[4]);
    e[5] = (prx | ptx) ? 1'b1 : (pacc ? 1'b0 : e[5]);
    e[7] = 1'b0;
    exp_s = e;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model();
    @(negedge clk);
    chk(stat == exp_s, tag, stat, exp_s);
    chk(irq == (exp_s != 8'h00), "R10 irq", {7'd0, irq}, {7'd0, exp_s != 8'h00});
    clear_pulses();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        n_fail++;
        $display("FAIL R1 watchdog actual=%0d expected=<200000", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    ms = 0; msk = '0; tmo = 0; ckf = 0; exp_s = '0;
    clear_pulses();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(stat == 8'h00 && irq == 0, "R1 reset", stat, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stat == 8'h00 && irq == 0, "R1 after release", stat, 8'h00);

    // R2 dynamic set and hold
    creq = 4'b0001; step("R2 set ch0");
    step("R2 hold ch0");
    // R3 clear by io read
    iord[0] = 1; step("R3 io read clears ch0");
    // R3 masked channel cannot set
    msk = 4'b0010; creq = 4'b0010; step("R3 masked ch1 stays low");
    msk = '0; creq = 4'b0100; step("R2 set ch2");
    msk = 4'b0100; step("R3 mask clears ch2");
    msk = '0;
    // R9 set wins over clear
    creq = 4'b1000; iord = 4'b1000; step("R9 set wins ch3");
    // R11 status read leaves channel bits and PCM bit
    prx = 1; step("R8 rx ready sets pcm");
    srd = 1; step("R11 status read no effect");
    pacc = 1; step("R8 access clears pcm");
    ptx = 1; step("R8 tx request sets pcm");
    ptx = 1; pacc = 1; step("R9 pcm set wins");
    pacc = 1; step("R8 pcm clear");
    // R6 time-out
    tmo = 1; step("R6 set");
    srd = 1; step("R6 read while active keeps");
    tmo = 0; step("R6 holds after cause drops");
    srd = 1; step("R6 read clears");
    // R7 clock failure
    ckf = 1; step("R7 set");
    srd = 1; step("R7 read while active keeps");
    ckf = 0; step("R7 holds");
    srd = 1; step("R7 read clears");
    // static mode
    creq = 4'b1010; step("R2 dyn set ch1 ch3");
    ms = 1; step("R5 static zeroes bits 1 and 3");
    gio = 12'h080; step("R4 gio sets bit0");
    cs = 4'b1000; step("R4 cs sets bit2");
    creq = 4'hF; msk = 4'hF; step("R4 ch_req and mask ignored");
    msk = '0;
    iord = 4'b0100; step("R4 io_rd2 clears bit2");
    iord = 4'b0001; step("R4 io_rd0 clears bit0");
    iord = 4'b1010; gio = 12'h001; step("R5 static bits stay zero");
    ms = 0; iord = 4'h1; step("R3 back to dynamic");

    // sweep
    for (int i = 0; i < 6000; i++) begin
      ms   = ($urandom_range(0, 7) == 0) ? ~ms : ms;
      creq = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      gio  = ($urandom_range(0, 3) == 0) ? 12'(1 << $urandom_range(0, 11)) : 12'h000;
      cs   = ($urandom_range(0, 3) == 0) ? 4'(1 << $urandom_range(0, 3)) : 4'h0;
      iord = ($urandom_range(0, 2) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
      msk  = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
      tmo  = ($urandom_range(0, 4) == 0);
      ckf  = ($urandom_range(0, 4) == 0);
      prx  = ($urandom_range(0, 5) == 0);
      ptx  = ($urandom_range(0, 5) == 0);
      pacc = ($urandom_range(0, 3) == 0);
      srd  = ($urandom_range(0, 2) == 0);
      step("R9 sweep");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule